// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C bus target that behaves like a small byte-addressed non-volatile memory. The storage is a 256-byte register array inside the block. The block watches the SCL and SDA lines through a synchroniser and finds START and STOP conditions. It drives SDA only by pulling it low, through an open-drain enable output. It answers to a 7-bit device address: a fixed `1010` prefix followed by three strap inputs. With those straps, up to eight copies can share one bus.

After the device address, a write transaction carries one word-address byte and then any number of data bytes. Data bytes land at the word address. Only the low three address bits advance between bytes, so a burst stays inside its 8-byte page and wraps within it.

A read transaction returns the byte at the internal pointer and then moves the pointer across the whole array, wrapping from the top byte back to zero. Three read forms are supported. A current-address read uses the pointer as left by the previous operation. A random read is a write header followed by a repeated START with the read bit set. A sequential read continues for as long as the master acknowledges. A write-protect input makes the whole array read-only.

Top module: `i2c_ee_target`

## Requirements
- R1: The block acknowledges a first byte whose upper seven bits equal binary 1010 followed by strap bits [2:1:0], with bit 0 as direction (0 = master writes, 1 = master reads). For any other address it never pulls SDA low, so the ninth bit reads as 1.
- R2: A STOP (SDA rising while SCL is high) at any point returns the block to idle with SDA released. After reset the block does not drive SDA.
- R3: Bytes move most significant bit first. The acknowledging side holds SDA low through the high phase of the ninth clock. The block changes its SDA drive only while SCL is low.
- R4: In a write, the byte after the device address sets the internal pointer, and each following data byte is stored at the pointer and acknowledged.
- R5: During a write burst the pointer's low 3 bits increment and wrap within the current 8-byte page, and the upper bits do not change.
- R6: While write-protect is high, the device address and the word address are still acknowledged. Data bytes are not acknowledged and the array is left unchanged.
- R7: A repeated START after the word address with a read header returns data from that address. Successive acknowledged reads step through the array with wrap from 0xFF to 0x00.
- R8: A read header with no preceding word address returns the byte at the pointer left by the previous transaction. That pointer is one past the last byte read, or the word address just set.
- R9: When the master does not acknowledge a read byte, the block stops driving SDA and ignores further clocks until the next START.
- R10: A START, including a repeated START, that carries a non-matching address returns the block to idle. The pointer is kept.
- R11: All 256 byte locations can be written and read back independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, well above the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level (asynchronous) |
| sda_i | input | 1 | SDA line level (asynchronous) |
| strap_i | input | 3 | Low three device-address bits |
| wp_i | input | 1 | Write protect, high makes the array read-only |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
The bench uses the default build: a 256-byte array, 8-byte pages and a two-stage synchroniser. It runs the bus at five system clocks per quarter SCL period. That size lets it fill every page with an arithmetic pattern and read the whole array back in a single sequential read, so every location and the 0xFF-to-0x00 wrap are covered. Before the fill, it tries all eight strap settings against all eight device addresses. The bench uses strap value 3 for the remaining tests, so that a strap bit wrongly tied to zero is caught.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

  // Controller phases; *_ACK phases cover the tail of bit 8 and the ninth clock
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_WADR,
    ST_WADR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_TX,
    ST_TX_ACK
  } ee_state_e;

  // Bus events seen after synchronisation
  typedef struct packed {
    logic scl;
    logic sda;
    logic scl_rise;
    logic scl_fall;
    logic start;
    logic stop;
  } bus_ev_t;

endpackage

// File: rtl/i2c_ee_linesync.sv
module i2c_ee_linesync
  import i2c_ee_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    scl_i,
  input  logic    sda_i,
  output bus_ev_t ev_o
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;
  logic              scl_s;
  logic              sda_s;

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  // Idle bus level is high, so the chain resets to ones
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe[0] <= scl_i;
      sda_pipe[0] <= sda_i;
      for (int i = 1; i < STAGES; i++) begin
        scl_pipe[i] <= scl_pipe[i-1];
        sda_pipe[i] <= sda_pipe[i-1];
      end
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_comb begin
    ev_o.scl      = scl_s;
    ev_o.sda      = sda_s;
    ev_o.scl_rise = scl_s & ~scl_q;
    ev_o.scl_fall = ~scl_s & scl_q;
    ev_o.start    = scl_s & scl_q & sda_q & ~sda_s;
    ev_o.stop     = scl_s & scl_q & ~sda_q & sda_s;
  end

endmodule

// File: rtl/i2c_ee_array.sv
module i2c_ee_array #(
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);

  logic [7:0] mem [DEPTH];

  // Storage without reset: contents are undefined until written
  always_ff @(posedge clk) begin
    if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/i2c_ee_ctrl.sv
module i2c_ee_ctrl
  import i2c_ee_pkg::*;
#(
  parameter int         AW         = 8,
  parameter int         PW         = 3,
  parameter logic [3:0] DEV_PREFIX = 4'b1010
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bus_ev_t       ev_i,
  input  logic [2:0]    strap_i,
  input  logic          wp_i,
  input  logic [7:0]    rdata_i,
  output logic [AW-1:0] ptr_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [7:0]    wdata_o,
  output logic          sda_oe_o
);

  ee_state_e     state_q, state_d;
  logic [2:0]    cnt_q, cnt_d;
  logic [7:0]    shreg_q, shreg_d;
  logic [7:0]    txreg_q, txreg_d;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          ack_q, ack_d;
  logic          slot_q, slot_d;
  logic          rw_q, rw_d;
  logic          mack_q, mack_d;
  logic          oe_q, oe_d;
  logic [7:0]    rx_byte;
  logic          in_ack;

  assign rx_byte = {shreg_q[6:0], ev_i.sda};
  assign ptr_o   = ptr_q;
  assign sda_oe_o = oe_q;

  // Next-state process
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    shreg_d = shreg_q;
    txreg_d = txreg_q;
    ptr_d   = ptr_q;
    ack_d   = ack_q;
    slot_d  = slot_q;
    rw_d    = rw_q;
    mack_d  = mack_q;
    we_o    = 1'b0;
    waddr_o = ptr_q;
    wdata_o = rx_byte;

    if (ev_i.stop) begin
      state_d = ST_IDLE;
      slot_d  = 1'b0;
    end else if (ev_i.start) begin
      state_d = ST_DEV;
      cnt_d   = 3'd0;
      slot_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_DEV, ST_WADR, ST_WDAT: begin
          if (ev_i.scl_rise) begin
            shreg_d = rx_byte;
            cnt_d   = cnt_q + 3'd1;
            if (cnt_q == 3'd7) begin
              ack_d = 1'b1;
              if (state_q == ST_DEV) begin
                if (rx_byte[7:1] == {DEV_PREFIX, strap_i}) begin
                  state_d = ST_DEV_ACK;
                  rw_d    = rx_byte[0];
                end else begin
                  state_d = ST_IDLE;
                end
              end else if (state_q == ST_WADR) begin
                ptr_d   = rx_byte[AW-1:0];
                state_d = ST_WADR_ACK;
              end else begin
                state_d = ST_WDAT_ACK;
                if (!wp_i) begin
                  we_o  = 1'b1;
                  ptr_d = {ptr_q[AW-1:PW], PW'(ptr_q[PW-1:0] + PW'(1))};
                end else begin
                  ack_d = 1'b0;
                end
              end
            end
          end
        end
        ST_DEV_ACK, ST_WADR_ACK, ST_WDAT_ACK: begin
          if (ev_i.scl_fall) begin
            if (!slot_q) begin
              slot_d = 1'b1;
            end else begin
              slot_d = 1'b0;
              cnt_d  = 3'd0;
              if (state_q == ST_DEV_ACK) begin
                if (rw_q) begin
                  state_d = ST_TX;
                  txreg_d = rdata_i;
                end else begin
                  state_d = ST_WADR;
                end
              end else if (state_q == ST_WADR_ACK) begin
                state_d = ST_WDAT;
              end else begin
                state_d = ack_q ? ST_WDAT : ST_IDLE;
              end
            end
          end
        end
        ST_TX: begin
          if (ev_i.scl_fall) begin
            txreg_d = {txreg_q[6:0], 1'b1};
            cnt_d   = cnt_q + 3'd1;
            if (cnt_q == 3'd7) begin
              state_d = ST_TX_ACK;
              ptr_d   = ptr_q + AW'(1);
            end
          end
        end
        ST_TX_ACK: begin
          if (ev_i.scl_rise) begin
            mack_d = ~ev_i.sda;
          end
          if (ev_i.scl_fall) begin
            cnt_d = 3'd0;
            if (mack_q) begin
              state_d = ST_TX;
              txreg_d = rdata_i;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end

    in_ack = (state_d == ST_DEV_ACK) || (state_d == ST_WADR_ACK) ||
             (state_d == ST_WDAT_ACK);
    oe_d = (in_ack && slot_d && ack_d) || ((state_d == ST_TX) && !txreg_d[7]);
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= 3'd0;
      shreg_q <= 8'h00;
      txreg_q <= 8'hFF;
      ptr_q   <= '0;
      ack_q   <= 1'b0;
      slot_q  <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      shreg_q <= shreg_d;
      txreg_q <= txreg_d;
      ptr_q   <= ptr_d;
      ack_q   <= ack_d;
      slot_q  <= slot_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
      oe_q    <= oe_d;
    end
  end

  // SDA drive may only change while the synchronised clock is low
  assert_oe_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_q != $past(oe_q)) |-> !ev_i.scl);

  // A STOP always leaves the block idle and silent
  assert_stop_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_i.stop |=> (state_q == ST_IDLE) && !oe_q);

  // Burst writes never leave the current page
  assert_page_stay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |=> (ptr_q[AW-1:PW] == $past(ptr_q[AW-1:PW])));

  // No store happens while protected
  assert_wp_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we_o |-> !wp_i);

  // The master owns SDA during its acknowledge slot
  assert_tx_ack_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TX_ACK) |-> !oe_q);

endmodule

// File: rtl/i2c_ee_target.sv
module i2c_ee_target #(
  parameter int         MEM_BYTES   = 256,
  parameter int         PAGE_BYTES  = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_PREFIX  = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_i,
  input  logic       wp_i,
  output logic       sda_oe_o
);

  import i2c_ee_pkg::*;

  // One word-address byte, so MEM_BYTES must not exceed 256
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);

  bus_ev_t       ev;
  logic          we;
  logic [AW-1:0] waddr;
  logic [7:0]    wdata;
  logic [AW-1:0] ptr;
  logic [7:0]    rdata;

  i2c_ee_linesync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_i (scl_i),
    .sda_i (sda_i),
    .ev_o  (ev)
  );

  i2c_ee_ctrl #(
    .AW         (AW),
    .PW         (PW),
    .DEV_PREFIX (DEV_PREFIX)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_i     (ev),
    .strap_i  (strap_i),
    .wp_i     (wp_i),
    .rdata_i  (rdata),
    .ptr_o    (ptr),
    .we_o     (we),
    .waddr_o  (waddr),
    .wdata_o  (wdata),
    .sda_oe_o (sda_oe_o)
  );

  i2c_ee_array #(
    .DEPTH (MEM_BYTES),
    .AW    (AW)
  ) u_array (
    .clk     (clk),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (ptr),
    .rdata_o (rdata)
  );

endmodule

// File: tb/i2c_ee_target_test.sv
module i2c_ee_target_test;

  localparam int Q = 5;  // system clocks per quarter SCL period

  logic       clk = 1'b0;
  logic       rst_n;
  logic       scl_m;
  logic       sda_m;
  logic       wp;
  logic [2:0] strap;
  logic       sda_oe;
  logic       sda_line;
  int         errors = 0;
  int         checks = 0;
  bit         done = 0;
  logic [7:0] expm [256];

  always #2 clk = ~clk;  // 250 MHz

  assign sda_line = sda_m & ~sda_oe;

  i2c_ee_target uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .strap_i  (strap),
    .wp_i     (wp),
    .sda_oe_o (sda_oe)
  );

  function automatic logic [7:0] pat(int a);
    return 8'(a * 37 + 11);
  endfunction

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  task automatic send_bit(logic v);
    sda_m = v; waitc(Q);
    scl_m = 1'b1; waitc(2 * Q);
    scl_m = 1'b0; waitc(Q);
  endtask

  task automatic recv_bit(output logic v);
    sda_m = 1'b1; waitc(Q);
    scl_m = 1'b1; waitc(Q);
    v = sda_line; waitc(Q);
    scl_m = 1'b0; waitc(Q);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; waitc(Q);
    scl_m = 1'b1; waitc(Q);
    sda_m = 1'b0; waitc(Q);
    scl_m = 1'b0; waitc(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; waitc(Q);
    scl_m = 1'b1; waitc(Q);
    sda_m = 1'b1; waitc(Q);
  endtask

  task automatic send_byte(logic [7:0] b, output logic acked);
    logic x;
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    recv_bit(x);
    acked = ~x;
  endtask

  task automatic recv_byte(output logic [7:0] b, input logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(x);
      b[i] = x;
    end
    send_bit(~ack);
  endtask

  function automatic logic [7:0] devb(logic rd);
    return {4'b1010, strap, rd};
  endfunction

  // Write header + word address + restart + read header
  task automatic rand_read_hdr(logic [7:0] wa, string req);
    logic a;
    i2c_start();
    send_byte(devb(1'b0), a); chk({req, " dev ack"}, a, 1);
    send_byte(wa, a);         chk({req, " waddr ack"}, a, 1);
    i2c_start();
    send_byte(devb(1'b1), a); chk({req, " read hdr ack"}, a, 1);
  endtask

  initial begin
    logic       a;
    logic [7:0] b;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; wp = 1'b0; strap = 3'd0;
    waitc(10);
    rst_n = 1'b1;
    waitc(6);
    chk("R2 reset drive", sda_oe, 0);

    // R1: every strap setting against every device address
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      for (int d = 0; d < 8; d++) begin
        i2c_start();
        send_byte({4'b1010, 3'(d), 1'b0}, a);
        chk("R1 address match", a, (d == s) ? 1 : 0);
        i2c_stop();
      end
      i2c_start();
      send_byte({4'b1011, 3'(s), 1'b0}, a);
      chk("R1 wrong prefix", a, 0);
      i2c_stop();
    end
    strap = 3'b011;

    // R4/R11: fill all pages
    for (int p = 0; p < 32; p++) begin
      i2c_start();
      send_byte(devb(1'b0), a); chk("R4 dev ack", a, 1);
      send_byte(8'(p * 8), a);  chk("R4 waddr ack", a, 1);
      for (int i = 0; i < 8; i++) begin
        send_byte(pat(p * 8 + i), a);
        chk("R4 data ack", a, 1);
        expm[p * 8 + i] = pat(p * 8 + i);
      end
      i2c_stop();
    end

    // R11/R7/R3: whole array in one sequential read
    rand_read_hdr(8'h00, "R7");
    for (int k = 0; k < 256; k++) begin
      recv_byte(b, k != 255);
      chk("R11 readback", b, expm[k]);
    end
    i2c_stop();

    // R5: burst crossing the page end wraps inside the page
    i2c_start();
    send_byte(devb(1'b0), a); chk("R5 dev ack", a, 1);
    send_byte(8'h15, a);      chk("R5 waddr ack", a, 1);
    for (int i = 0; i < 5; i++) begin
      send_byte(8'(8'hC0 + i), a);
      chk("R5 data ack", a, 1);
      expm[8'h10 + ((5 + i) % 8)] = 8'(8'hC0 + i);
    end
    i2c_stop();
    rand_read_hdr(8'h10, "R5");
    for (int i = 0; i < 8; i++) begin
      recv_byte(b, i != 7);
      chk("R5 page wrap", b, expm[8'h10 + i]);
    end
    i2c_stop();

    // R7: sequential read wraps past 0xFF
    rand_read_hdr(8'hFE, "R7");
    for (int i = 0; i < 4; i++) begin
      recv_byte(b, i != 3);
      chk("R7 array wrap", b, expm[(8'hFE + i) % 256]);
    end
    i2c_stop();

    // R8 current address, then R9 silence after master NACK
    i2c_start();
    send_byte(devb(1'b1), a); chk("R8 read hdr ack", a, 1);
    recv_byte(b, 1'b0);
    chk("R8 current address", b, expm[2]);
    recv_byte(b, 1'b0);
    chk("R9 released after nack", b, 8'hFF);
    i2c_stop();

    // R6: write protect
    wp = 1'b1;
    i2c_start();
    send_byte(devb(1'b0), a); chk("R6 dev ack under wp", a, 1);
    send_byte(8'h40, a);      chk("R6 waddr ack under wp", a, 1);
    send_byte(8'h5A, a);      chk("R6 data nack under wp", a, 0);
    i2c_stop();
    wp = 1'b0;
    rand_read_hdr(8'h40, "R6");
    recv_byte(b, 1'b0);
    chk("R6 memory unchanged", b, expm[8'h40]);
    i2c_stop();

    // R2: STOP right after word address, pointer kept
    i2c_start();
    send_byte(devb(1'b0), a); chk("R2 dev ack", a, 1);
    send_byte(8'h30, a);      chk("R2 waddr ack", a, 1);
    i2c_stop();
    chk("R2 released after stop", sda_oe, 0);
    i2c_start();
    send_byte(devb(1'b1), a); chk("R2 read hdr ack", a, 1);
    recv_byte(b, 1'b0);
    chk("R2 pointer after stop", b, expm[8'h30]);
    i2c_stop();

    // R10: repeated START with another address goes idle
    i2c_start();
    send_byte(devb(1'b0), a); chk("R10 dev ack", a, 1);
    send_byte(8'h20, a);      chk("R10 waddr ack", a, 1);
    i2c_start();
    send_byte({4'b1010, ~strap, 1'b1}, a);
    chk("R10 foreign address nack", a, 0);
    recv_byte(b, 1'b0);
    chk("R10 silent when idle", b, 8'hFF);
    i2c_stop();
    i2c_start();
    send_byte(devb(1'b1), a); chk("R10 read hdr ack", a, 1);
    recv_byte(b, 1'b0);
    chk("R10 pointer kept", b, expm[8'h20]);
    i2c_stop();

    waitc(10);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog all actual=hung expected=finished");
      summary();
      $finish;
    end
  end

endmodule